// File: doc/BRIEF.md
# Bridge Fault Supervisor

This block collects the protection conditions of a three-phase bridge gate controller and turns them into two gating commands for the gate-drive stage: a coast command that drives every gate low, and a high-side inhibit that turns off only the upper switches. It also drives an active-high fault flag. Every analog threshold is resolved upstream, so each condition arrives here as one comparator bit. This includes the supply undervoltage detector with its hysteresis, the thermal detector and one drain-source detector for each phase.

A bad rotor-position code, supply undervoltage, over-temperature and the clear input all force a coast. None of these is stored: each one follows its source. A phase is shorted to ground when its high-side gate is on and its drain-source comparator still reports a large drop. That comparator is only trusted after a parameterised settling time has passed since the gate turned on. A detected short is latched and raises the high-side inhibit. The latch is released by a commutation strobe, by the clear input or by the power-up reset.

Top module: `bridge_fault_sup`

## Requirements
- R1: While the power-up reset `rstN` is low, and after it is released with no fault present, `coastCmd`, `hsInhibit` and `faultFlag` are all 0.
- R2: A position code `hallCode` of 3'b000 or 3'b111 sampled at a clock edge sets `coastCmd` and `faultFlag` after that edge. Both fall after the first edge that samples a valid code, unless another source is still active.
- R3: `uvTrip` = 1 sampled at an edge sets `coastCmd` after that edge. The coast ends after the first edge that samples `uvTrip` = 0.
- R4: `otTrip` = 1 sampled at an edge sets `coastCmd` and `faultFlag` after that edge. Both clear after the first edge that samples `otTrip` = 0.
- R5: For phase p (bit p of `desatCmp` and `hsGateOn`), `desatCmp[p]` is ignored at the first SETTLE_CYC edges at which `hsGateOn[p]` is sampled high in an unbroken run.
- R6: `desatCmp[p]` = 1 together with `hsGateOn[p]` = 1 at the (SETTLE_CYC+1)th or a later edge of that run latches a short. After that edge `hsInhibit` = 1 and `faultFlag` = 1. A short alone does not raise `coastCmd`.
- R7: A latched short persists after the comparator or the gate drops, until it is cleared.
- R8: `commStrobe` = 1 sampled at an edge clears every latched short after that edge. If a new short is detected at the same edge, the clear wins.
- R9: `clrReq` = 1 sampled at an edge forces `coastCmd` = 1 after that edge and clears every latched short, with clear winning over a new detection.
- R10: `faultFlag` is the OR of the bad-code, undervoltage, over-temperature and latched-short conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous power-up reset, active low |
| clrReq | input | 1 | Clear input: coast and release latched shorts |
| hallCode | input | 3 | Rotor position code |
| uvTrip | input | 1 | Supply undervoltage comparator, with hysteresis |
| otTrip | input | 1 | Over-temperature comparator, with hysteresis |
| desatCmp | input | NPH | Per-phase high-side drain-source excess comparator |
| hsGateOn | input | NPH | Per-phase high-side gate state |
| commStrobe | input | 1 | Commutation event strobe |
| coastCmd | output | 1 | All gates off |
| hsInhibit | output | 1 | High-side gates off |
| faultFlag | output | 1 | Active-high fault indication |

## Verification
Every output is one register stage behind the inputs that cause it. Bad codes, undervoltage, over-temperature, the clear input and a short detection all show at the outputs after the first clock edge that samples them. The settling window moves the first honoured drain-source sample to the (SETTLE_CYC+1)th edge of an unbroken gate-on run. The bench changes inputs just after the falling edge and advances a behavioural model at each rising edge. It compares all three outputs at the next falling edge, so every expected value is taken exactly one edge after its stimulus. Windows with the comparator high at edges 1 to SETTLE_CYC of a run, and clear and detection landing on the same edge, check that off-by-one and priority errors are caught.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
  typedef struct packed {
    logic clearShort;  // release all latched shorts this edge
    logic coastReq;    // coast condition seen this cycle
    logic srcFault;    // non-latched fault source seen this cycle
  } bfs_strobe_t;
endpackage

// File: rtl/bfs_ctrl.sv
module bfs_ctrl
  import bfs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clrReq,
  input  logic [2:0]  hallCode,
  input  logic        uvTrip,
  input  logic        otTrip,
  input  logic        commStrobe,
  output bfs_strobe_t strobe,
  output logic        coastQ,
  output logic        srcFaultQ
);
  logic hallBad;

  always_comb begin
    hallBad           = (hallCode == 3'b000) || (hallCode == 3'b111);
    strobe.clearShort = clrReq | commStrobe;
    strobe.srcFault   = hallBad | uvTrip | otTrip;
    strobe.coastReq   = clrReq | strobe.srcFault;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coastQ    <= 1'b0;
      srcFaultQ <= 1'b0;
    end else begin
      coastQ    <= strobe.coastReq;
      srcFaultQ <= strobe.srcFault;
    end
  end
endmodule

// File: rtl/bfs_short_dp.sv
module bfs_short_dp
  import bfs_pkg::*;
#(
  parameter int NPH        = 3,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  bfs_strobe_t      strobe,
  input  logic [NPH-1:0]   desatCmp,
  input  logic [NPH-1:0]   hsGateOn,
  output logic [NPH-1:0]   shortQ
);
  localparam int CW = $clog2(SETTLE_CYC + 1);

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic [CW-1:0] onCnt;
    logic          armed;
    logic          detect;

    always_comb begin
      armed  = (onCnt == CW'(SETTLE_CYC));
      detect = armed & hsGateOn[p] & desatCmp[p];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        onCnt     <= '0;
        shortQ[p] <= 1'b0;
      end else begin
        if (!hsGateOn[p])  onCnt <= '0;
        else if (!armed)   onCnt <= onCnt + CW'(1);
        if (strobe.clearShort) shortQ[p] <= 1'b0;
        else if (detect)       shortQ[p] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bridge_fault_sup.sv
module bridge_fault_sup
  import bfs_pkg::*;
#(
  parameter int NPH        = 3,
  parameter int SETTLE_CYC = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           clrReq,
  input  logic [2:0]     hallCode,
  input  logic           uvTrip,
  input  logic           otTrip,
  input  logic [NPH-1:0] desatCmp,
  input  logic [NPH-1:0] hsGateOn,
  input  logic           commStrobe,
  output logic           coastCmd,
  output logic           hsInhibit,
  output logic           faultFlag
);
  bfs_strobe_t    strobe;
  logic           coastQ;
  logic           srcFaultQ;
  logic [NPH-1:0] shortQ;

  bfs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clrReq(clrReq), .hallCode(hallCode),
    .uvTrip(uvTrip), .otTrip(otTrip), .commStrobe(commStrobe),
    .strobe(strobe), .coastQ(coastQ), .srcFaultQ(srcFaultQ)
  );

  bfs_short_dp #(.NPH(NPH), .SETTLE_CYC(SETTLE_CYC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .desatCmp(desatCmp), .hsGateOn(hsGateOn), .shortQ(shortQ)
  );

  always_comb begin
    coastCmd  = coastQ;
    hsInhibit = |shortQ;
    faultFlag = srcFaultQ | hsInhibit;
  end
endmodule

// File: rtl/bridge_fault_sup_chk.sv
module bridge_fault_sup_chk (
  input logic       clk,
  input logic       rstN,
  input logic       clrReq,
  input logic [2:0] hallCode,
  input logic       uvTrip,
  input logic       otTrip,
  input logic       commStrobe,
  input logic       coastCmd,
  input logic       hsInhibit,
  input logic       faultFlag
);
  // R2
  bad_code_coast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hallCode == 3'b000 || hallCode == 3'b111) |=> (coastCmd && faultFlag));
  // R3
  uv_coast_chk: assert property (@(posedge clk) disable iff (!rstN)
    uvTrip |=> coastCmd);
  // R4
  ot_coast_chk: assert property (@(posedge clk) disable iff (!rstN)
    otTrip |=> (coastCmd && faultFlag));
  // R7
  short_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsInhibit && !commStrobe && !clrReq) |=> hsInhibit);
  // R8
  comm_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    commStrobe |=> !hsInhibit);
  // R9
  clr_coast_chk: assert property (@(posedge clk) disable iff (!rstN)
    clrReq |=> (coastCmd && !hsInhibit));
  // R10
  short_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    hsInhibit |-> faultFlag);
endmodule

bind bridge_fault_sup bridge_fault_sup_chk u_chk (
  .clk(clk), .rstN(rstN), .clrReq(clrReq), .hallCode(hallCode),
  .uvTrip(uvTrip), .otTrip(otTrip), .commStrobe(commStrobe),
  .coastCmd(coastCmd), .hsInhibit(hsInhibit), .faultFlag(faultFlag)
);

// File: tb/sim_bridge_fault_sup.sv
module sim_bridge_fault_sup;
  localparam int CLK_PERIOD = 10;
  localparam int NPH = 3;
  localparam int SETTLE = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           clrReq = 1'b0;
  logic [2:0]     hallCode = 3'b101;
  logic           uvTrip = 1'b0;
  logic           otTrip = 1'b0;
  logic [NPH-1:0] desatCmp = '0;
  logic [NPH-1:0] hsGateOn = '0;
  logic           commStrobe = 1'b0;
  logic           coastCmd, hsInhibit, faultFlag;

  int tests = 0;
  int fails = 0;
  int onRun[NPH];
  bit latched[NPH];
  bit expCoast = 0, expInh = 0, expFlag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bridge_fault_sup #(.NPH(NPH), .SETTLE_CYC(SETTLE)) u0 (
    .clk(clk), .rstN(rstN), .clrReq(clrReq), .hallCode(hallCode),
    .uvTrip(uvTrip), .otTrip(otTrip), .desatCmp(desatCmp),
    .hsGateOn(hsGateOn), .commStrobe(commStrobe),
    .coastCmd(coastCmd), .hsInhibit(hsInhibit), .faultFlag(faultFlag)
  );

  task automatic check1(string tag, string what, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(string tag);
    check1(tag, "coastCmd", coastCmd, expCoast);
    check1(tag, "hsInhibit", hsInhibit, expInh);
    check1(tag, "faultFlag", faultFlag, expFlag);
  endtask

  // one clock: apply inputs, advance model at the rising edge, compare at the falling edge
  task automatic step(input logic [2:0] h, input logic uv, input logic ot,
                      input logic [NPH-1:0] ds, input logic [NPH-1:0] g,
                      input logic cm, input logic cl, input string tag);
    bit bad, anyLatch;
    hallCode = h; uvTrip = uv; otTrip = ot; desatCmp = ds;
    hsGateOn = g; commStrobe = cm; clrReq = cl;
    @(posedge clk);
    bad = (h == 3'b000) || (h == 3'b111);
    anyLatch = 0;
    for (int p = 0; p < NPH; p++) begin
      bit hit;
      hit = g[p] && ds[p] && (onRun[p] >= SETTLE);
      if (cm || cl) latched[p] = 0;
      else if (hit) latched[p] = 1;
      onRun[p] = g[p] ? ((onRun[p] < SETTLE) ? onRun[p] + 1 : SETTLE) : 0;
      anyLatch |= latched[p];
    end
    expCoast = cl | bad | uv | ot;
    expInh   = anyLatch;
    expFlag  = bad | uv | ot | anyLatch;
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    for (int p = 0; p < NPH; p++) begin onRun[p] = 0; latched[p] = 0; end
    repeat (2) @(negedge clk);
    compareAll("R1");                      // held in reset
    rstN = 1'b1;
    step(3'b101, 0, 0, '0, '0, 0, 0, "R1");
    step(3'b011, 0, 0, '0, '0, 0, 0, "R1");
    // bad position codes
    step(3'b000, 0, 0, '0, '0, 0, 0, "R2");
    step(3'b110, 0, 0, '0, '0, 0, 0, "R2");
    step(3'b111, 0, 0, '0, '0, 0, 0, "R2");
    step(3'b001, 0, 0, '0, '0, 0, 0, "R2");
    // undervoltage
    step(3'b001, 1, 0, '0, '0, 0, 0, "R3");
    step(3'b001, 1, 0, '0, '0, 0, 0, "R3");
    step(3'b001, 0, 0, '0, '0, 0, 0, "R3");
    // over-temperature
    step(3'b100, 0, 1, '0, '0, 0, 0, "R4");
    step(3'b100, 0, 1, '0, '0, 0, 0, "R4");
    step(3'b100, 0, 0, '0, '0, 0, 0, "R4");
    // settle window: comparator high from the first gate-on edge
    for (int i = 0; i < SETTLE; i++) step(3'b100, 0, 0, 3'b001, 3'b001, 0, 0, "R5");
    step(3'b100, 0, 0, 3'b001, 3'b001, 0, 0, "R6");
    // hold after gate and comparator drop
    step(3'b100, 0, 0, 3'b000, 3'b000, 0, 0, "R7");
    step(3'b110, 0, 0, 3'b000, 3'b000, 0, 0, "R7");
    // commutation clear
    step(3'b110, 0, 0, 3'b000, 3'b000, 1, 0, "R8");
    // gate-on run broken before settling on phase 1
    for (int i = 0; i < SETTLE - 1; i++) step(3'b110, 0, 0, 3'b010, 3'b010, 0, 0, "R5");
    step(3'b110, 0, 0, 3'b010, 3'b000, 0, 0, "R5");
    for (int i = 0; i < SETTLE; i++) step(3'b110, 0, 0, 3'b010, 3'b010, 0, 0, "R5");
    // detection coincides with commutation: clear wins
    step(3'b110, 0, 0, 3'b010, 3'b010, 1, 0, "R8");
    step(3'b010, 0, 0, 3'b010, 3'b010, 0, 0, "R6");
    // short plus over-temperature: flag is the OR
    step(3'b010, 0, 1, 3'b000, 3'b010, 0, 0, "R10");
    step(3'b010, 0, 0, 3'b000, 3'b000, 0, 0, "R10");
    // clear input
    step(3'b010, 0, 0, 3'b000, 3'b000, 0, 1, "R9");
    step(3'b011, 0, 0, 3'b000, 3'b000, 0, 0, "R9");
    // phase 2 late detection, then clear input at the same edge as detection
    for (int i = 0; i < SETTLE + 2; i++) step(3'b011, 0, 0, 3'b000, 3'b100, 0, 0, "R5");
    step(3'b011, 0, 0, 3'b100, 3'b100, 0, 1, "R9");
    step(3'b011, 0, 0, 3'b100, 3'b100, 0, 0, "R6");
    step(3'b011, 0, 0, 3'b000, 3'b000, 0, 0, "R7");
    // power-up reset releases latch
    rstN = 1'b0;
    for (int p = 0; p < NPH; p++) begin onRun[p] = 0; latched[p] = 0; end
    expCoast = 0; expInh = 0; expFlag = 0;
    @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    step(3'b011, 0, 0, '0, '0, 0, 0, "R1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule